// File: doc/BRIEF.md
# FSK Proximity Tag Waveform Generator

This block produces the load-modulation bit stream that a low-frequency proximity tag sends back to a reader. A 44-bit identifier arrives as a 12-bit upper word and a 32-bit lower word. The block captures it on a start pulse and then emits one output level for every carrier-cycle tick. A level of 1 leaves the coil open and a level of 0 shorts it. The analog drive stage applies each level for one carrier period.

Every frame is built from two tones. The fast tone repeats an 8-cycle pattern and the slow tone repeats a 10-cycle pattern. A frame opens with a marker made of eight tone half-bits. That marker is deliberately not valid Manchester code, so a receiver can find the frame edge. Each data bit follows as a pair of half-bits in opposite tones, most significant bit first. One short fast-tone separator period comes before every group of four bits. The frame repeats without a gap for as long as the block stays enabled. A one-cycle strobe marks the first emitted level of every frame, so downstream logic or a test harness can align to it.

Top module: `fsk_tag_wavegen`

## Requirements
- R1: While reset is held, and in the first cycle after it, `mod_out` and `frame_start` are both 0.
- R2: A `start` seen while `enable` is 1 captures `{id_hi, id_lo}` as the identifier and arms a new frame. A `start` seen while `enable` is 0 is ignored, and `mod_out` stays 0.
- R3: `mod_out` takes a new level only in the cycle after a `tick` and holds its value otherwise. A `tick` in the same cycle as an accepted `start` is discarded, so the first frame level appears after the next `tick`.
- R4: A fast half-bit is the pattern 11000000 sent six times (48 ticks). A slow half-bit is the pattern 1110000000 sent five times (50 ticks). In each pattern the leftmost level is emitted first.
- R5: Identifier bit 43 is `id_hi[11]` and bit 0 is `id_lo[0]`. Bits are sent from 43 down to 0. A 1 is a slow half-bit then a fast half-bit, and a 0 is a fast half-bit then a slow half-bit.
- R6: Every frame begins with the marker half-bits fast, fast, fast, slow, slow, slow, fast, slow, in that order.
- R7: One separator 11000000 (8 ticks) is sent before each bit whose index leaves remainder 3 when divided by 4 (43, 39, ... 3). A whole frame is therefore 4792 ticks.
- R8: After the last half-bit of bit 0, the next tick starts the marker of a new frame that uses the same captured identifier.
- R9: A change on `id_hi` or `id_lo` without a new `start` has no effect on the stream. A `start` in the middle of a frame restarts at the marker with the newly captured identifier.
- R10: `frame_start` is 1 for exactly the cycle that shows the first level of each marker, and is 0 in every other cycle.
- R11: When `enable` is 0, `mod_out` and `frame_start` are 0 from the next cycle on, and ticks are ignored. Raising `enable` again emits nothing until a new `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Allows generation; 0 stops the stream and forces the output to 0 |
| start | input | 1 | Captures the identifier and restarts the frame |
| id_hi | input | 12 | Identifier bits 43..32 |
| id_lo | input | 32 | Identifier bits 31..0 |
| tick | input | 1 | One pulse per carrier cycle |
| mod_out | output | 1 | Coil state: 1 open, 0 shorted |
| frame_start | output | 1 | One-cycle strobe on the first level of each frame |

## Verification
Two events can land in the same cycle: an accepted `start` and a carrier `tick`. The start has to win, and the tick has to be dropped without a level being emitted. The bench provokes this by pulsing `start` while ticks arrive on every clock. It also restarts in the middle of a frame under an irregular tick pattern. A queue-based model rebuilds the frame from the requirements and is compared on every clock. The first level and the strobe are expected one tick after the start cycle, not in it. The spacing between strobes is also measured and checked against the 4792-tick frame.

// File: rtl/fsk_tag_pkg.sv
package fsk_tag_pkg;

  typedef enum logic [1:0] {
    SEG_MARK,
    SEG_SEP,
    SEG_FIRST,
    SEG_SECOND
  } seg_kind_e;

  // Number of ticks in one full frame for a given parameter set.
  function automatic int frame_len(int id_w, int group, int mark_len, int mark_tones,
                                   int short_div, int short_reps, int long_div, int long_reps);
    int total;
    total = 0;
    for (int i = 0; i < mark_len; i++) begin
      total += ((mark_tones >> i) & 1) != 0 ? long_div * long_reps : short_div * short_reps;
    end
    total += id_w * (short_div * short_reps + long_div * long_reps);
    total += (id_w / group) * short_div;
    return total;
  endfunction

endpackage

// File: rtl/fsk_tone_cell.sv
module fsk_tone_cell #(
  parameter int SHORT_DIV = 8,
  parameter int SHORT_ON  = 2,
  parameter int LONG_DIV  = 10,
  parameter int LONG_ON   = 3,
  parameter int REP_W     = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             step,
  input  logic             use_long,
  input  logic [REP_W-1:0] reps,
  output logic             level,
  output logic             cell_end,
  output logic             at_origin
);
  localparam int DIV_MAX = (LONG_DIV > SHORT_DIV) ? LONG_DIV : SHORT_DIV;
  localparam int PH_W    = $clog2(DIV_MAX);

  logic [PH_W-1:0]  phase_q;
  logic [PH_W-1:0]  period_last;
  logic [PH_W-1:0]  on_len;
  logic [REP_W-1:0] rep_q;
  logic             period_end;

  always_comb begin
    period_last = use_long ? PH_W'(LONG_DIV - 1) : PH_W'(SHORT_DIV - 1);
    on_len      = use_long ? PH_W'(LONG_ON) : PH_W'(SHORT_ON);
    level       = (phase_q < on_len);
    period_end  = (phase_q == period_last);
    cell_end    = period_end && (rep_q == reps - REP_W'(1));
    at_origin   = (phase_q == '0) && (rep_q == '0);
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      phase_q <= '0;
      rep_q   <= '0;
    end else if (step) begin
      if (period_end) begin
        phase_q <= '0;
        rep_q   <= cell_end ? '0 : rep_q + REP_W'(1);
      end else begin
        phase_q <= phase_q + PH_W'(1);
      end
    end
  end

endmodule

// File: rtl/fsk_frame_seq.sv
module fsk_frame_seq
  import fsk_tag_pkg::*;
#(
  parameter int                ID_W       = 44,
  parameter int                GROUP      = 4,
  parameter int                MARK_LEN   = 8,
  parameter logic [MARK_LEN-1:0] MARK_TONES = 8'hB8,
  parameter int                SHORT_REPS = 6,
  parameter int                LONG_REPS  = 5,
  parameter int                REP_W      = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             advance,
  input  logic [ID_W-1:0]  id,
  output logic             use_long,
  output logic [REP_W-1:0] reps,
  output logic             frame_head
);
  localparam int BI_W = $clog2(ID_W);
  localparam int MI_W = (MARK_LEN > 1) ? $clog2(MARK_LEN) : 1;

  seg_kind_e       kind_q;
  logic [MI_W-1:0] mark_q;
  logic [BI_W-1:0] bit_q;
  logic            cur_bit;

  function automatic logic opens_group(input logic [BI_W-1:0] b);
    return (int'(b) % GROUP) == (GROUP - 1);
  endfunction

  always_comb begin
    cur_bit = id[bit_q];
    unique case (kind_q)
      SEG_MARK:   use_long = MARK_TONES[mark_q];
      SEG_SEP:    use_long = 1'b0;
      SEG_FIRST:  use_long = cur_bit;
      default:    use_long = !cur_bit;
    endcase
    if (kind_q == SEG_SEP) reps = REP_W'(1);
    else if (use_long)     reps = REP_W'(LONG_REPS);
    else                   reps = REP_W'(SHORT_REPS);
    frame_head = (kind_q == SEG_MARK) && (mark_q == '0);
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      kind_q <= SEG_MARK;
      mark_q <= '0;
      bit_q  <= BI_W'(ID_W - 1);
    end else if (advance) begin
      unique case (kind_q)
        SEG_MARK: begin
          if (mark_q == MI_W'(MARK_LEN - 1)) begin
            bit_q  <= BI_W'(ID_W - 1);
            kind_q <= opens_group(BI_W'(ID_W - 1)) ? SEG_SEP : SEG_FIRST;
          end else begin
            mark_q <= mark_q + MI_W'(1);
          end
        end
        SEG_SEP:   kind_q <= SEG_FIRST;
        SEG_FIRST: kind_q <= SEG_SECOND;
        default: begin
          if (bit_q == '0) begin
            kind_q <= SEG_MARK;
            mark_q <= '0;
          end else begin
            bit_q  <= bit_q - BI_W'(1);
            kind_q <= opens_group(bit_q - BI_W'(1)) ? SEG_SEP : SEG_FIRST;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/fsk_tag_wavegen.sv
module fsk_tag_wavegen #(
  parameter int ID_HI_W    = 12,
  parameter int ID_LO_W    = 32,
  parameter int GROUP      = 4,
  parameter int SHORT_DIV  = 8,
  parameter int SHORT_ON   = 2,
  parameter int SHORT_REPS = 6,
  parameter int LONG_DIV   = 10,
  parameter int LONG_ON    = 3,
  parameter int LONG_REPS  = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enable,
  input  logic               start,
  input  logic [ID_HI_W-1:0] id_hi,
  input  logic [ID_LO_W-1:0] id_lo,
  input  logic               tick,
  output logic               mod_out,
  output logic               frame_start
);
  localparam int ID_W     = ID_HI_W + ID_LO_W;
  localparam int REPS_MAX = (LONG_REPS > SHORT_REPS) ? LONG_REPS : SHORT_REPS;
  localparam int REP_W    = $clog2(REPS_MAX + 1);
  localparam int MARK_LEN = 8;
  localparam logic [MARK_LEN-1:0] MARK_TONES = 8'hB8;

  logic            running_q;
  logic [ID_W-1:0] id_q;
  logic            restart;
  logic            step;
  logic            use_long;
  logic [REP_W-1:0] reps;
  logic            level;
  logic            cell_end;
  logic            at_origin;
  logic            frame_head;

  assign restart = enable && start;
  assign step    = running_q && enable && tick && !start;

  fsk_frame_seq #(
    .ID_W       (ID_W),
    .GROUP      (GROUP),
    .MARK_LEN   (MARK_LEN),
    .MARK_TONES (MARK_TONES),
    .SHORT_REPS (SHORT_REPS),
    .LONG_REPS  (LONG_REPS),
    .REP_W      (REP_W)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .clear      (restart),
    .advance    (step && cell_end),
    .id         (id_q),
    .use_long   (use_long),
    .reps       (reps),
    .frame_head (frame_head)
  );

  fsk_tone_cell #(
    .SHORT_DIV (SHORT_DIV),
    .SHORT_ON  (SHORT_ON),
    .LONG_DIV  (LONG_DIV),
    .LONG_ON   (LONG_ON),
    .REP_W     (REP_W)
  ) u_cell (
    .clk       (clk),
    .rst       (rst),
    .clear     (restart),
    .step      (step),
    .use_long  (use_long),
    .reps      (reps),
    .level     (level),
    .cell_end  (cell_end),
    .at_origin (at_origin)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      running_q   <= 1'b0;
      id_q        <= '0;
      mod_out     <= 1'b0;
      frame_start <= 1'b0;
    end else if (!enable) begin
      running_q   <= 1'b0;
      mod_out     <= 1'b0;
      frame_start <= 1'b0;
    end else if (start) begin
      running_q   <= 1'b1;
      id_q        <= {id_hi, id_lo};
      frame_start <= 1'b0;
    end else if (step) begin
      mod_out     <= level;
      frame_start <= frame_head && at_origin;
    end else begin
      frame_start <= 1'b0;
    end
  end

endmodule

// File: rtl/fsk_tag_wavegen_chk.sv
module fsk_tag_wavegen_chk
  import fsk_tag_pkg::*;
#(
  parameter int ID_W       = 44,
  parameter int GROUP      = 4,
  parameter int SHORT_DIV  = 8,
  parameter int SHORT_REPS = 6,
  parameter int LONG_DIV   = 10,
  parameter int LONG_REPS  = 5
) (
  input logic clk,
  input logic rst,
  input logic enable,
  input logic start,
  input logic tick,
  input logic mod_out,
  input logic frame_start
);
  localparam int FRAME_TICKS = frame_len(ID_W, GROUP, 8, 'hB8, SHORT_DIV, SHORT_REPS,
                                         LONG_DIV, LONG_REPS);
  localparam int CNT_W = $clog2(FRAME_TICKS + 2);

  logic             running;
  logic             emitted;
  logic             armed;
  logic [CNT_W-1:0] since;

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      emitted <= 1'b0;
      armed   <= 1'b0;
      since   <= '0;
    end else begin
      emitted <= running && enable && tick && !start;
      if (!enable) running <= 1'b0;
      else if (start) running <= 1'b1;
      if (!enable || start) begin
        armed <= 1'b0;
      end else if (emitted) begin
        if (frame_start) begin
          armed <= 1'b1;
          since <= CNT_W'(1);
        end else begin
          since <= since + CNT_W'(1);
        end
      end
    end
  end

  // R10
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !frame_start);

  // R6
  marker_opens_high_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> mod_out);

  // R11
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!mod_out && !frame_start));

  // R3
  hold_without_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && (!tick || start)) |=> $stable(mod_out));

  // R3
  strobe_needs_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && (!tick || start)) |=> !frame_start);

  // R7
  frame_length_chk: assert property (@(posedge clk) disable iff (rst)
    (emitted && frame_start && armed) |-> (since == CNT_W'(FRAME_TICKS)));

endmodule

bind fsk_tag_wavegen fsk_tag_wavegen_chk #(
  .ID_W       (ID_HI_W + ID_LO_W),
  .GROUP      (GROUP),
  .SHORT_DIV  (SHORT_DIV),
  .SHORT_REPS (SHORT_REPS),
  .LONG_DIV   (LONG_DIV),
  .LONG_REPS  (LONG_REPS)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .enable      (enable),
  .start       (start),
  .tick        (tick),
  .mod_out     (mod_out),
  .frame_start (frame_start)
);

// File: tb/tb_fsk_tag_wavegen.sv
module tb_fsk_tag_wavegen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0;
  logic        start = 1'b0;
  logic [11:0] id_hi = '0;
  logic [31:0] id_lo = '0;
  logic        tick = 1'b0;
  logic        mod_out;
  logic        frame_start;

  int    checks = 0;
  int    fails = 0;
  bit    done = 0;
  string cur_req = "R1";
  int    tick_mode = 0;
  int    cyc = 0;

  always #2 clk = ~clk;

  fsk_tag_wavegen dut (
    .clk(clk), .rst(rst), .enable(enable), .start(start),
    .id_hi(id_hi), .id_lo(id_lo), .tick(tick),
    .mod_out(mod_out), .frame_start(frame_start)
  );

  // ---------------- reference model ----------------
  bit          frame_q[$];
  int          pos = 0;
  bit          m_run = 0, m_out = 0, m_fs = 0, m_emit = 0;
  logic [43:0] m_id = '0;

  // R4: fast = 6 x 11000000, slow = 5 x 1110000000
  task automatic push_half(input bit slow);
    if (slow) repeat (5) begin
      repeat (3) frame_q.push_back(1'b1);
      repeat (7) frame_q.push_back(1'b0);
    end else repeat (6) begin
      repeat (2) frame_q.push_back(1'b1);
      repeat (6) frame_q.push_back(1'b0);
    end
  endtask

  task automatic build_frame(input logic [43:0] id);
    bit marker[8] = '{0, 0, 0, 1, 1, 1, 0, 1};  // R6
    frame_q.delete();
    foreach (marker[k]) push_half(marker[k]);
    for (int b = 43; b >= 0; b--) begin
      if (b % 4 == 3) begin  // R7 separator
        repeat (2) frame_q.push_back(1'b1);
        repeat (6) frame_q.push_back(1'b0);
      end
      push_half(id[b]);      // R5: 1 -> slow first, 0 -> fast first
      push_half(!id[b]);
    end
  endtask

  always @(posedge clk) begin
    m_emit = 0;
    if (rst) begin
      m_run = 0; m_out = 0; m_fs = 0; pos = 0;
    end else if (!enable) begin
      m_run = 0; m_out = 0; m_fs = 0;
    end else if (start) begin
      m_run = 1; m_id = {id_hi, id_lo}; build_frame(m_id); pos = 0; m_fs = 0;
    end else if (m_run && tick) begin
      m_out = frame_q[pos];
      m_fs = (pos == 0);
      pos = (pos + 1) % frame_q.size();
      m_emit = 1;
    end else begin
      m_fs = 0;
    end
  end

  // ---------------- per-cycle comparison ----------------
  int  fs_seen = 0;
  int  since = 0;
  int  last_int = 0;
  bit  armed = 0;

  always @(negedge clk) begin
    cyc++;
    tick = (tick_mode == 0) ? 1'b1 : ((cyc % 3) != 1 && (cyc % 7) != 2);
    if (!rst) begin
      checks++;
      if (mod_out !== m_out || frame_start !== m_fs) begin
        fails++;
        $display("FAIL %s cycle %0d: mod_out=%b frame_start=%b expected %b %b",
                 cur_req, cyc, mod_out, frame_start, m_out, m_fs);
      end
      if (frame_start) fs_seen++;
      if (start) armed = 0;
      if (m_emit) begin
        if (frame_start) begin
          if (armed) last_int = since;
          since = 1; armed = 1;
        end else since++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start(input logic [11:0] hi, input logic [31:0] lo);
    id_hi = hi; id_lo = lo; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    // R1: reset state
    wait_cycles(5);
    check(mod_out == 0 && frame_start == 0, "R1", {mod_out, frame_start}, 0);
    rst = 1'b0;
    wait_cycles(1);
    check(mod_out == 0 && frame_start == 0, "R1", {mod_out, frame_start}, 0);

    // R2: start while disabled is ignored
    cur_req = "R2";
    pulse_start(12'hFFF, 32'hFFFF_FFFF);
    wait_cycles(60);
    check(mod_out == 0 && fs_seen == 0, "R2", fs_seen, 0);

    // R3 collision: start with tick high; R4 R5 R6 R7 R8 R10 over two frames
    cur_req = "R3/R4/R5/R6/R8";
    enable = 1'b1;
    fs_seen = 0;
    pulse_start(12'hA5C, 32'h9E37_0F21);
    wait_cycles(900);
    // R9: id input change mid-frame has no effect
    cur_req = "R9";
    id_hi = 12'h0F0; id_lo = 32'h5555_AAAA;
    wait_cycles(2 * 4792 + 100 - 901);
    check(fs_seen == 3, "R10", fs_seen, 3);
    check(last_int == 4792, "R7", last_int, 4792);
    check(last_int == 4792, "R8", last_int, 4792);

    // R3: irregular ticks, output holds between them
    cur_req = "R3";
    tick_mode = 1;
    wait_cycles(3000);

    // R9: restart mid-frame with new identifier
    cur_req = "R9";
    pulse_start(12'h3C1, 32'h0000_0001);
    wait_cycles(8000);
    check(last_int == 4792, "R9", last_int, 4792);

    // R11: enable low silences output, ticks ignored
    cur_req = "R11";
    enable = 1'b0;
    wait_cycles(1);
    check(mod_out == 0 && frame_start == 0, "R11", mod_out, 0);
    fs_seen = 0;
    wait_cycles(200);
    enable = 1'b1;
    wait_cycles(300);
    check(mod_out == 0 && fs_seen == 0, "R11", fs_seen, 0);

    // Restart after re-enable, all-ones and all-zeros patterns
    cur_req = "R5";
    tick_mode = 0;
    fs_seen = 0;
    pulse_start(12'hFFF, 32'hFFFF_FFFF);
    wait_cycles(4800);
    check(fs_seen == 2, "R10", fs_seen, 2);
    cur_req = "R5";
    pulse_start(12'h000, 32'h0000_0000);
    wait_cycles(4800);
    check(last_int == 4792, "R7", last_int, 4792);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule